// File: doc/BRIEF.md
# Asynchronous static RAM strobe sequencer

This block sits between a synchronous host and an external asynchronous static RAM of 256K bytes. The host hands over one word access at a time through a valid/ready request port carrying an 18-bit address, a write flag and a byte of write data. The block turns each request into a timed strobe pattern on the RAM pins: two chip selects of opposite polarity, a write strobe, an output enable, the address, and a split data bus (output value, output enable, input value) that a pad ring joins into one bidirectional bus. For a read it returns the captured byte with a one-cycle response pulse.

All RAM timing limits are parameters in clock cycles. The integrator derives them by rounding the nanosecond limits up to whole clock periods. The block then stretches every phase to the longest limit that governs it. All RAM pins come straight from flops, so they cannot glitch. Between accesses the RAM is deselected, both strobes are inactive and the data driver is off.

A read holds the output enable low for RD_LEN = max(T_ACC, T_CYC) cycles. A write spends one setup cycle with the RAM selected and the write strobe high. It then holds the write strobe low for WP_LEN = max(T_WP, T_OFF + T_DW, T_CYC - 1) cycles. During a write the output enable stays high, and the controller's own data driver turns on only T_OFF cycles into the pulse.

Top module: `sram_ctl`

## Requirements
- R1: After reset and whenever idle, ram_ce_n=1, ram_ce=0, ram_we_n=1, ram_oe_n=1, ram_dq_oe=0, req_ready=1 and rsp_valid=0.
- R2: The RAM is selected only with both enables active together (ram_ce_n=0 and ram_ce=1 in the same cycle), during every cycle of an access.
- R3: A read keeps ram_oe_n=0 and ram_we_n=1 for exactly RD_LEN cycles. The byte on ram_dq_in at the end of that window appears on rsp_rdata with rsp_valid high for one cycle, RD_LEN cycles after the accepting clock edge.
- R4: A write first spends one cycle selected with ram_we_n=1, then holds ram_we_n=0 for exactly WP_LEN cycles. ram_addr stays constant from acceptance until the strobe rises.
- R5: During a write ram_oe_n stays 1, and ram_dq_oe is 1 only for the last WP_LEN - T_OFF cycles of the write pulse, with ram_dq_out stable while it is on.
- R6: A byte written to an address is returned by a later read of that address, across all-zero, all-one and alternating bit patterns and the lowest and highest addresses.
- R7: req_ready is high only while idle. A request is taken on a clock edge where req_valid and req_ready are both high. Requests presented while busy are ignored and leave ram_addr and the strobes unchanged.
- R8: Consecutive acceptances are RD_LEN + 1 cycles apart after a read and WP_LEN + 2 cycles apart after a write, so no access is shorter than T_CYC.
- R9: The controller never enables its data driver while the RAM may still be driving the bus, including the tail after a read ends.
- R10: A write produces no rsp_valid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle pulse marking read data |
| rsp_rdata | output | 8 | Captured read byte |
| ram_addr | output | 18 | RAM address pins |
| ram_ce_n | output | 1 | Active-low chip select |
| ram_ce | output | 1 | Active-high chip select |
| ram_we_n | output | 1 | Active-low write strobe |
| ram_oe_n | output | 1 | Active-low output enable |
| ram_dq_out | output | 8 | Value driven onto the data bus |
| ram_dq_oe | output | 1 | Data bus driver enable |
| ram_dq_in | input | 8 | Value sampled from the data bus |

## Verification
The read response pulse and the acceptance of the next request can fall in the same cycle. When a read's select window closes, rsp_valid rises together with req_ready. A host that holds req_valid high then has its next request taken on the very next edge. The bench provokes this with a read followed at once by a held write request. In the cycle of the response it checks that ready and rsp_valid are both high and that the data is correct. It then judges the following write against a behavioural RAM model, which flags bus contention with the RAM's output-disable tail, short pulses, short setup and address changes under the strobe.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_READ   = 2'd1,
        ST_WSET   = 2'd2,
        ST_WPULSE = 2'd3
    } ctl_state_e;

    // Internal strobe set, all active high; pin polarity is applied at the top.
    typedef struct packed {
        logic sel;
        logic wr;
        logic rd;
        logic drv;
    } strobe_t;

    localparam strobe_t STROBE_PARK = '{sel: 1'b0, wr: 1'b0, rd: 1'b0, drv: 1'b0};

    function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                                 input int unsigned period_ns);
        return (ns + period_ns - 1) / period_ns;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
    parameter int unsigned CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic [CW-1:0] count,
    output logic          done
);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (count != '0) begin
            count <= count - 1'b1;
        end
    end

    assign done = (count == '0);

endmodule

// File: rtl/sram_ctl_fsm.sv
module sram_ctl_fsm
    import sram_ctl_pkg::*;
#(
    parameter int unsigned T_ACC = 4,
    parameter int unsigned T_CYC = 4,
    parameter int unsigned T_WP  = 2,
    parameter int unsigned T_OFF = 2,
    parameter int unsigned T_DW  = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    req_valid,
    input  logic    req_we,
    output logic    req_ready,
    output logic    accept,
    output logic    capture,
    output strobe_t strobe
);

    localparam int unsigned RD_LEN = umax(umax(T_ACC, T_CYC), 1);
    localparam int unsigned WP_LEN = umax(umax(umax(T_WP, T_OFF + T_DW), umax(T_CYC, 1) - 1), 1);
    localparam int unsigned CW     = $clog2(umax(RD_LEN, WP_LEN) + 1);
    localparam int unsigned DRV_AT = WP_LEN - T_OFF;

    localparam logic [CW-1:0] RD_LOAD = CW'(RD_LEN - 1);
    localparam logic [CW-1:0] WP_LOAD = CW'(WP_LEN - 1);
    localparam logic [CW-1:0] DRV_CMP = CW'(DRV_AT);

    ctl_state_e    state;
    logic          t_load;
    logic [CW-1:0] t_val;
    logic [CW-1:0] t_count;
    logic          t_done;

    assign req_ready = (state == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign capture   = (state == ST_READ) && t_done;

    always_comb begin
        t_load = 1'b0;
        t_val  = RD_LOAD;
        if (accept && !req_we) begin
            t_load = 1'b1;
            t_val  = RD_LOAD;
        end else if (state == ST_WSET) begin
            t_load = 1'b1;
            t_val  = WP_LOAD;
        end
    end

    sram_ctl_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (t_load),
        .load_val (t_val),
        .count    (t_count),
        .done     (t_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            strobe <= STROBE_PARK;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        strobe.sel <= 1'b1;
                        if (req_we) begin
                            state <= ST_WSET;
                        end else begin
                            state     <= ST_READ;
                            strobe.rd <= 1'b1;
                        end
                    end
                end
                ST_READ: begin
                    if (t_done) begin
                        state  <= ST_IDLE;
                        strobe <= STROBE_PARK;
                    end
                end
                ST_WSET: begin
                    state      <= ST_WPULSE;
                    strobe.wr  <= 1'b1;
                    strobe.drv <= (T_OFF == 0);
                end
                ST_WPULSE: begin
                    if (t_done) begin
                        state  <= ST_IDLE;
                        strobe <= STROBE_PARK;
                    end else if (t_count <= DRV_CMP) begin
                        strobe.drv <= 1'b1;
                    end
                end
                default: begin
                    state  <= ST_IDLE;
                    strobe <= STROBE_PARK;
                end
            endcase
        end
    end

endmodule

// File: rtl/sram_ctl_dpath.sv
module sram_ctl_dpath #(
    parameter int unsigned AW = 18,
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          accept,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic          capture,
    input  logic [DW-1:0] ram_dq_in,
    output logic [AW-1:0] ram_addr,
    output logic [DW-1:0] wdata,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ram_addr  <= '0;
            wdata     <= '0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            if (accept) begin
                ram_addr <= req_addr;
                wdata    <= req_wdata;
            end
            rsp_valid <= capture;
            if (capture) begin
                rsp_rdata <= ram_dq_in;
            end
        end
    end

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int unsigned AW    = 18,
    parameter int unsigned DW    = 8,
    parameter int unsigned T_ACC = 4,
    parameter int unsigned T_CYC = 4,
    parameter int unsigned T_WP  = 2,
    parameter int unsigned T_OFF = 2,
    parameter int unsigned T_DW  = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_we,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    output logic [AW-1:0] ram_addr,
    output logic          ram_ce_n,
    output logic          ram_ce,
    output logic          ram_we_n,
    output logic          ram_oe_n,
    output logic [DW-1:0] ram_dq_out,
    output logic          ram_dq_oe,
    input  logic [DW-1:0] ram_dq_in
);

    strobe_t strobe;
    logic    accept;
    logic    capture;

    sram_ctl_fsm #(
        .T_ACC (T_ACC),
        .T_CYC (T_CYC),
        .T_WP  (T_WP),
        .T_OFF (T_OFF),
        .T_DW  (T_DW)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_we    (req_we),
        .req_ready (req_ready),
        .accept    (accept),
        .capture   (capture),
        .strobe    (strobe)
    );

    sram_ctl_dpath #(.AW(AW), .DW(DW)) u_dpath (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .capture   (capture),
        .ram_dq_in (ram_dq_in),
        .ram_addr  (ram_addr),
        .wdata     (ram_dq_out),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    // Pin polarity: every pin is a direct flop output.
    assign ram_ce_n  = ~strobe.sel;
    assign ram_ce    =  strobe.sel;
    assign ram_we_n  = ~strobe.wr;
    assign ram_oe_n  = ~strobe.rd;
    assign ram_dq_oe =  strobe.drv;

endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
    parameter int unsigned AW = 18
) (
    input logic          clk,
    input logic          rst,
    input logic          req_valid,
    input logic          req_ready,
    input logic          rsp_valid,
    input logic [AW-1:0] ram_addr,
    input logic          ram_ce_n,
    input logic          ram_ce,
    input logic          ram_we_n,
    input logic          ram_oe_n,
    input logic          ram_dq_oe
);

    AST_IDLE_PARKED: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (ram_ce_n && !ram_ce && ram_we_n && ram_oe_n && !ram_dq_oe)); // R1

    AST_READ_CLEAN: assert property (@(posedge clk) disable iff (rst)
        !ram_oe_n |-> (ram_we_n && !ram_dq_oe && !ram_ce_n && ram_ce)); // R3

    AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid); // R3

    AST_WE_AFTER_SETUP: assert property (@(posedge clk) disable iff (rst)
        $fell(ram_we_n) |-> ($past(!ram_ce_n) && $stable(ram_addr))); // R4

    AST_ADDR_UNDER_WE: assert property (@(posedge clk) disable iff (rst)
        !ram_we_n |=> $stable(ram_addr)); // R4

    AST_DRV_IN_PULSE: assert property (@(posedge clk) disable iff (rst)
        ram_dq_oe |-> (!ram_we_n && ram_oe_n && !ram_ce_n)); // R5

    AST_BUSY_AFTER_TAKE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready); // R7

    AST_RSP_FROM_READ: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(!ram_oe_n)); // R10

endmodule

bind sram_ctl sram_ctl_chk #(.AW(AW)) u_chk (.*);

// File: tb/sim_sram_ctl.sv
module sim_sram_ctl;
    import sram_ctl_pkg::*;

    localparam int unsigned CLK_PERIOD = 20;
    localparam int unsigned T_ACC = ns_to_cycles(70, CLK_PERIOD);
    localparam int unsigned T_CYC = ns_to_cycles(70, CLK_PERIOD);
    localparam int unsigned T_WP  = ns_to_cycles(35, CLK_PERIOD);
    localparam int unsigned T_OFF = ns_to_cycles(30, CLK_PERIOD);
    localparam int unsigned T_DW  = ns_to_cycles(30, CLK_PERIOD);
    // Expected phase lengths from the requirements.
    localparam int E_RD = (T_ACC > T_CYC) ? T_ACC : T_CYC;
    localparam int E_WA = (T_WP > T_OFF + T_DW) ? T_WP : T_OFF + T_DW;
    localparam int E_WP = (E_WA > T_CYC - 1) ? E_WA : T_CYC - 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_we = 1'b0;
    logic [17:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rsp_valid;
    logic [7:0]  rsp_rdata;
    logic [17:0] ram_addr;
    logic        ram_ce_n, ram_ce, ram_we_n, ram_oe_n, ram_dq_oe;
    logic [7:0]  ram_dq_out, ram_dq_in;

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;

    sram_ctl #(.T_ACC(T_ACC), .T_CYC(T_CYC), .T_WP(T_WP), .T_OFF(T_OFF), .T_DW(T_DW)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ram_addr(ram_addr),
        .ram_ce_n(ram_ce_n), .ram_ce(ram_ce), .ram_we_n(ram_we_n), .ram_oe_n(ram_oe_n),
        .ram_dq_out(ram_dq_out), .ram_dq_oe(ram_dq_oe), .ram_dq_in(ram_dq_in)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // ---------------- behavioural RAM model ----------------
    logic [7:0]  mem [int];
    logic [7:0]  model_q = '0;
    logic        model_drv = 1'b0;
    logic [17:0] last_addr = '0;
    logic [7:0]  last_dq = '0;
    bit          prev_wr = 0, prev_sel = 0;
    int addr_age = 0, rd_age = 0, wp_cnt = 0, ds_cnt = 0, sel_cnt = 0, hz_left = 0;
    int vio_tim = 0, vio_bus = 0, vio_cyc = 0;

    function automatic logic [7:0] mem_val(input logic [17:0] a);
        if (mem.exists(int'(a))) return mem[int'(a)];
        return a[7:0] ^ 8'hA5;
    endfunction

    assign ram_dq_in = model_drv ? model_q : 8'h00;

    always @(negedge clk) begin
        if (!rst) begin
            bit sel, wr, rdc, achg;
            sel  = !ram_ce_n && ram_ce;
            wr   = sel && !ram_we_n;
            rdc  = sel && ram_we_n && !ram_oe_n;
            achg = (ram_addr != last_addr);
            if (achg && wr) vio_tim++;
            if (prev_wr && !wr) begin
                if (wp_cnt < int'(T_WP)) vio_tim++;
                if (ds_cnt < int'(T_DW)) vio_tim++;
                if (addr_age < int'(T_CYC)) vio_tim++;
                mem[int'(last_addr)] = last_dq;
            end
            if (prev_sel && !sel && sel_cnt < int'(T_CYC)) vio_cyc++;
            if (wr && ram_dq_oe)
                ds_cnt = (ds_cnt > 0 && ram_dq_out == last_dq) ? ds_cnt + 1 : 1;
            else
                ds_cnt = 0;
            addr_age = achg ? 1 : addr_age + 1;
            wp_cnt   = wr ? wp_cnt + 1 : 0;
            rd_age   = rdc ? (achg ? 1 : rd_age + 1) : 0;
            sel_cnt  = sel ? sel_cnt + 1 : 0;
            if (rdc) hz_left = int'(T_OFF);
            else if (hz_left > 0) hz_left--;
            model_drv = rdc || (hz_left > 0);
            if (model_drv && ram_dq_oe) vio_bus++;
            model_q = (rd_age >= int'(T_ACC)) ? mem_val(ram_addr) : ~mem_val(ram_addr);
            if (wr && ram_dq_oe) last_dq = ram_dq_out;
            prev_wr   = wr;
            prev_sel  = sel;
            last_addr = ram_addr;
        end
    end

    // ---------------- checking helpers ----------------
    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    // Present a request and return the cycle stamp at the negedge after acceptance.
    task automatic issue(input logic [17:0] a, input bit we, input logic [7:0] d, output int c0);
        @(negedge clk);
        req_addr  = a;
        req_we    = we;
        req_wdata = d;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        c0 = cyc;
        req_valid = 1'b0;
    endtask

    task automatic do_write(input logic [17:0] a, input logic [7:0] d);
        int c0, wl, dv, guard;
        bit oe_ok, addr_ok, rsp_seen, sel_ok;
        issue(a, 1'b1, d, c0);
        chk(!ram_ce_n && ram_ce, "R2 select in write setup", {ram_ce_n, ram_ce}, 2'b01);
        chk(ram_we_n && !ram_dq_oe, "R4 setup cycle strobe high", {ram_we_n, ram_dq_oe}, 2'b10);
        wl = 0; dv = 0; guard = 0; oe_ok = 1; addr_ok = 1; rsp_seen = 0; sel_ok = 1;
        while (!req_ready && guard < 40) begin
            @(negedge clk);
            guard++;
            if (!req_ready) begin
                if (!ram_we_n) wl++;
                if (ram_dq_oe) dv++;
                if (!ram_oe_n) oe_ok = 0;
                if (ram_addr != a) addr_ok = 0;
                if (ram_ce_n || !ram_ce) sel_ok = 0;
            end
            if (rsp_valid) rsp_seen = 1;
        end
        chk(wl == E_WP, "R4 write pulse length", wl, E_WP);
        chk(addr_ok, "R4 address held", ram_addr, a);
        chk(oe_ok, "R5 output enable high in write", 0, 1);
        chk(dv == E_WP - int'(T_OFF), "R5 driver cycles", dv, E_WP - int'(T_OFF));
        chk(sel_ok, "R2 select held", 0, 1);
        chk(cyc - c0 == E_WP + 1, "R8 write occupancy", cyc - c0, E_WP + 1);
        chk(!rsp_seen, "R10 no response on write", 1, 0);
    endtask

    task automatic do_read(input logic [17:0] a, input logic [7:0] exp);
        int c0, ol, guard;
        bit sel_ok;
        issue(a, 1'b0, 8'h00, c0);
        ol = 0; guard = 0; sel_ok = 1;
        while (!rsp_valid && guard < 40) begin
            if (!ram_oe_n && ram_we_n) ol++;
            if (ram_ce_n || !ram_ce) sel_ok = 0;
            @(negedge clk);
            guard++;
        end
        chk(ol == E_RD, "R3 output enable window", ol, E_RD);
        chk(sel_ok, "R2 select during read", 0, 1);
        chk(cyc - c0 == E_RD, "R3 response latency", cyc - c0, E_RD);
        chk(rsp_rdata == exp, "R6 read data", rsp_rdata, exp);
        @(negedge clk);
        chk(!rsp_valid, "R3 response one cycle", rsp_valid, 0);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        @(negedge clk);
        chk(ram_ce_n && !ram_ce && ram_we_n && ram_oe_n && !ram_dq_oe, "R1 parked pins",
            {ram_ce_n, ram_ce, ram_we_n, ram_oe_n, ram_dq_oe}, 5'b10110);
        chk(req_ready && !rsp_valid, "R1 ready and no response", {req_ready, rsp_valid}, 2'b10);
    endtask

    task automatic t_patterns();
        do_write(18'h00000, 8'h00);
        do_write(18'h3FFFF, 8'hFF);
        do_write(18'h15555, 8'h5A);
        do_read(18'h00000, 8'h00);
        do_read(18'h3FFFF, 8'hFF);
        do_read(18'h15555, 8'h5A);
        do_read(18'h00123, 8'h23 ^ 8'hA5);
        t_reset();
    endtask

    task automatic t_busy_ignore();
        int c0;
        bit ok;
        do_write(18'h2AAAA, 8'hC3);
        issue(18'h2AAAA, 1'b0, 8'h00, c0);
        req_addr = 18'h01111; req_we = 1'b1; req_wdata = 8'h77; req_valid = 1'b1;
        ok = 1;
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            if (req_ready || ram_addr != 18'h2AAAA || ram_oe_n || !ram_we_n) ok = 0;
        end
        req_valid = 1'b0;
        chk(ok, "R7 busy request ignored", ram_addr, 18'h2AAAA);
        while (!rsp_valid) @(negedge clk);
        chk(rsp_rdata == 8'hC3, "R7 data after ignored request", rsp_rdata, 8'hC3);
        do_read(18'h01111, 8'h11 ^ 8'hA5);
    endtask

    task automatic t_back_to_back();
        int c0, c1, guard;
        bit was_rdy, seen;
        do_write(18'h0F0F0, 8'h96);
        issue(18'h0F0F0, 1'b0, 8'h00, c0);
        req_addr = 18'h30303; req_we = 1'b1; req_wdata = 8'h3C; req_valid = 1'b1;
        was_rdy = 0; seen = 0; guard = 0; c1 = c0;
        while (guard < 40) begin
            @(negedge clk);
            guard++;
            if (was_rdy) begin
                c1 = cyc;
                break;
            end
            if (rsp_valid) begin
                seen = 1;
                chk(req_ready, "R8 ready with response", req_ready, 1);
                chk(rsp_rdata == 8'h96, "R3 data at overlap", rsp_rdata, 8'h96);
            end
            was_rdy = req_ready;
        end
        req_valid = 1'b0;
        chk(seen, "R3 response seen", 0, 1);
        chk(c1 - c0 == E_RD + 1, "R8 read-to-next gap", c1 - c0, E_RD + 1);
        while (!req_ready) @(negedge clk);
        chk(cyc - c1 == E_WP + 1, "R8 write occupancy held", cyc - c1, E_WP + 1);
        do_read(18'h30303, 8'h3C);
        // held write then read: gap WP_LEN + 2
        issue(18'h00042, 1'b1, 8'hE1, c0);
        req_addr = 18'h00042; req_we = 1'b0; req_valid = 1'b1;
        was_rdy = 0; guard = 0;
        while (guard < 40) begin
            @(negedge clk);
            guard++;
            if (was_rdy) begin
                c1 = cyc;
                break;
            end
            was_rdy = req_ready;
        end
        req_valid = 1'b0;
        chk(c1 - c0 == E_WP + 2, "R8 write-to-next gap", c1 - c0, E_WP + 2);
        while (!rsp_valid) @(negedge clk);
        chk(rsp_rdata == 8'hE1, "R6 read after held write", rsp_rdata, 8'hE1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_patterns();
        t_busy_ignore();
        t_back_to_back();
        repeat (4) @(negedge clk);
        chk(vio_bus == 0, "R9 bus contention count", vio_bus, 0);
        chk(vio_tim == 0, "R4 R5 write timing violations", vio_tim, 0);
        chk(vio_cyc == 0, "R8 cycle time violations", vio_cyc, 0);
        report();
    end

endmodule